// File: doc/BRIEF.md
# Ping-Pong Buffer Job Scheduler

This block sits between an external loader and an embedded processor that share a bank of dual-port RAM buffers. The loader fills a buffer through its own RAM port and pulses a per-buffer "loaded" strobe. The scheduler hands loaded buffers to the processor one at a time by raising that buffer's interrupt line. It then waits for the processor to set the matching done port, and passes the finished buffer back to the loader for unloading and refilling. All other buffers stay free for the loader while the processor works, so the processor never stalls on a refill.

Each buffer slot runs a four-state machine: SLOT_EMPTY, SLOT_LOADED, SLOT_ACTIVE and SLOT_DONE. It moves along four transitions: FILL (EMPTY to LOADED on a load strobe), START (LOADED to ACTIVE when granted), FINISH (ACTIVE to DONE on the processor's done), and DRAIN (DONE to EMPTY on an unload strobe, which also emits a one-cycle clear of the processor's done port). The scheduler runs a two-state machine, SCH_IDLE and SCH_RUN, with three transitions: GRANT (IDLE to RUN when a loaded buffer exists), CHAIN (RUN to RUN when a job completes and another buffer is loaded), and RELEASE (RUN to IDLE when a job completes and nothing is loaded). The active job is held as a one-hot grant vector, which is driven directly onto the interrupt lines.

Top module: `pp_job_sched`

## Requirements
- R1: After reset, irq_o, unload_rdy_o, done_clr_o and err_o are all zero and every bit of free_o is one.
- R2: A load_i pulse on an empty buffer, with no job running, makes free_o for that buffer drop after the first clock edge. The buffer's irq_o bit rises after the second edge.
- R3: At most one bit of irq_o is high in any cycle.
- R4: A granted irq_o bit stays high until a rising edge of the matching cpu_done_i is sampled. It drops after that edge, and unload_rdy_o for that buffer rises after the same edge.
- R5: When a job completes, the next grant goes to the first loaded buffer found by searching upward in index from the completed buffer and wrapping at the top (index modulo the buffer count). That irq_o bit rises on the same edge that the finished one drops. After reset the search starts at buffer 0.
- R6: A load_i pulse on a buffer that is not empty has no effect: its free_o, unload_rdy_o and irq_o bits keep their values.
- R7: An unload_i pulse on a buffer with unload_rdy_o high sets its free_o bit and clears its unload_rdy_o bit after the next edge. It also drives its done_clr_o bit high for exactly that one cycle. An unload_i pulse on any other buffer is ignored.
- R8: A rising edge of cpu_done_i on a buffer that is not granted leaves irq_o unchanged and sets err_o, which stays high until reset.
- R9: Loading buffers that are not granted while a job is running does not change irq_o. A buffer loaded during a job is granted later by the R5 rule.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_i | input | NBUF | Per-buffer strobe: loader finished filling the buffer |
| unload_i | input | NBUF | Per-buffer strobe: loader finished draining the buffer |
| cpu_done_i | input | NBUF | Processor done ports, one level per buffer |
| irq_o | output | NBUF | Per-buffer interrupt to the processor, one-hot or zero |
| done_clr_o | output | NBUF | One-cycle clear pulse for the processor's done port |
| unload_rdy_o | output | NBUF | Buffer holds results and may be unloaded |
| free_o | output | NBUF | Buffer is empty and may be refilled |
| err_o | output | 1 | Sticky flag: done seen from a buffer that was not granted |

## Verification
Directed sequences cover the cases that need exact values. A single load shows the two-edge latency from strobe to interrupt. Buffers loaded out of index order while another job runs show the upward, wrapping search and the back-to-back hand-off with no gap. A stray done, a load aimed at a finished buffer and an unload aimed at the active buffer show that misdirected strobes are ignored or flagged, not acted on. A constrained-random phase then issues sparse load and unload strobes on every buffer, with a processor model that answers interrupts after random delays. A cycle-level reference model is compared on every cycle. This phase separates scheduling races, such as a buffer that is refilled, drained and granted in adjacent cycles, from the orderly directed flow.

// File: rtl/sched_pkg.sv
package sched_pkg;

    // Per-buffer lifecycle
    typedef enum logic [1:0] {
        SLOT_EMPTY  = 2'd0,
        SLOT_LOADED = 2'd1,
        SLOT_ACTIVE = 2'd2,
        SLOT_DONE   = 2'd3
    } slot_state_e;

    // Scheduler lifecycle
    typedef enum logic {
        SCH_IDLE = 1'b0,
        SCH_RUN  = 1'b1
    } sch_state_e;

endpackage

// File: rtl/buf_slot.sv
module buf_slot
    import sched_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        load_i,
    input  logic        start_i,
    input  logic        finish_i,
    input  logic        unload_i,
    output slot_state_e state_o,
    output logic        clr_o
);

    slot_state_e st_q, st_d;
    logic        clr_q, clr_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= SLOT_EMPTY;
            clr_q <= 1'b0;
        end else begin
            st_q  <= st_d;
            clr_q <= clr_d;
        end
    end

    // Next state and outputs
    always_comb begin
        st_d  = st_q;
        clr_d = 1'b0;
        unique case (st_q)
            SLOT_EMPTY:  if (load_i)   st_d = SLOT_LOADED;      // FILL
            SLOT_LOADED: if (start_i)  st_d = SLOT_ACTIVE;      // START
            SLOT_ACTIVE: if (finish_i) st_d = SLOT_DONE;        // FINISH
            SLOT_DONE:   if (unload_i) begin                    // DRAIN
                st_d  = SLOT_EMPTY;
                clr_d = 1'b1;
            end
        endcase
    end

    assign state_o = st_q;
    assign clr_o   = clr_q;

    // R5
    start_only_loaded_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> st_q == SLOT_LOADED);

    // R4
    finish_only_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        finish_i |-> st_q == SLOT_ACTIVE);

    // R7
    clr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_q |=> !clr_q);

    // R7
    clr_after_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_q |-> st_q == SLOT_EMPTY);

endmodule

// File: rtl/rr_pick.sv
module rr_pick #(
    parameter int N  = 8,
    parameter int IW = 3
) (
    input  logic [N-1:0]  req_i,
    input  logic [IW-1:0] base_i,
    output logic [N-1:0]  gnt_o,
    output logic          any_o
);

    // Search upward from base+1, wrapping, first hit wins
    always_comb begin
        gnt_o = '0;
        any_o = 1'b0;
        for (int k = 1; k <= N; k++) begin
            int idx;
            idx = (int'(base_i) + k) % N;
            if (!any_o && req_i[idx]) begin
                gnt_o[idx] = 1'b1;
                any_o      = 1'b1;
            end
        end
    end

    // R3
    always_comb begin
        rr_onehot_chk: assert ($onehot0(gnt_o));
    end

endmodule

// File: rtl/pp_job_sched.sv
module pp_job_sched
    import sched_pkg::*;
#(
    parameter int NBUF = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NBUF-1:0] load_i,
    input  logic [NBUF-1:0] unload_i,
    input  logic [NBUF-1:0] cpu_done_i,
    output logic [NBUF-1:0] irq_o,
    output logic [NBUF-1:0] done_clr_o,
    output logic [NBUF-1:0] unload_rdy_o,
    output logic [NBUF-1:0] free_o,
    output logic            err_o
);

    localparam int IW = (NBUF > 1) ? $clog2(NBUF) : 1;

    slot_state_e     slot_st [NBUF];
    logic [NBUF-1:0] loaded_vec, active_vec, done_vec, empty_vec;
    logic [NBUF-1:0] start_vec, fin_vec, clr_vec, rise_vec, stray_vec, pick_vec;
    logic [NBUF-1:0] grant_q, grant_d, done_prev_q;
    logic [IW-1:0]   last_q, last_d, base, cur_idx;
    sch_state_e      sch_q, sch_d;
    logic            err_q, err_d, completing, pick_any;

    // Per-buffer slots
    for (genvar g = 0; g < NBUF; g++) begin : g_slot
        buf_slot u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .load_i   (load_i[g]),
            .start_i  (start_vec[g]),
            .finish_i (fin_vec[g]),
            .unload_i (unload_i[g]),
            .state_o  (slot_st[g]),
            .clr_o    (clr_vec[g])
        );
        assign loaded_vec[g] = (slot_st[g] == SLOT_LOADED);
        assign active_vec[g] = (slot_st[g] == SLOT_ACTIVE);
        assign done_vec[g]   = (slot_st[g] == SLOT_DONE);
        assign empty_vec[g]  = (slot_st[g] == SLOT_EMPTY);
    end

    // Done-port edge detection
    assign rise_vec   = cpu_done_i & ~done_prev_q;
    assign fin_vec    = rise_vec & grant_q;
    assign stray_vec  = rise_vec & ~grant_q;
    assign completing = |fin_vec;

    always_comb begin
        cur_idx = '0;
        for (int i = 0; i < NBUF; i++)
            if (grant_q[i]) cur_idx = IW'(i);
    end

    assign base = completing ? cur_idx : last_q;

    rr_pick #(.N(NBUF), .IW(IW)) u_pick (
        .req_i  (loaded_vec),
        .base_i (base),
        .gnt_o  (pick_vec),
        .any_o  (pick_any)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sch_q       <= SCH_IDLE;
            grant_q     <= '0;
            last_q      <= IW'(NBUF - 1);
            done_prev_q <= '0;
            err_q       <= 1'b0;
        end else begin
            sch_q       <= sch_d;
            grant_q     <= grant_d;
            last_q      <= last_d;
            done_prev_q <= cpu_done_i;
            err_q       <= err_d;
        end
    end

    // Transitions
    always_comb begin
        sch_d     = sch_q;
        grant_d   = grant_q;
        last_d    = last_q;
        start_vec = '0;
        err_d     = err_q | (|stray_vec);
        unique case (sch_q)
            SCH_IDLE: begin
                if (pick_any) begin                 // GRANT
                    sch_d     = SCH_RUN;
                    grant_d   = pick_vec;
                    start_vec = pick_vec;
                end
            end
            SCH_RUN: begin
                if (completing) begin
                    last_d    = cur_idx;
                    grant_d   = pick_vec;
                    start_vec = pick_vec;
                    sch_d     = pick_any ? SCH_RUN      // CHAIN
                                         : SCH_IDLE;    // RELEASE
                end
            end
        endcase
    end

    // Outputs
    assign irq_o        = grant_q;
    assign done_clr_o   = clr_vec;
    assign unload_rdy_o = done_vec;
    assign free_o       = empty_vec;
    assign err_o        = err_q;

    // R3
    irq_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(irq_o));

    // R4
    irq_on_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o & ~active_vec) == '0);

    // R4
    irq_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        completing |=> (irq_o & $past(fin_vec)) == '0);

    // R4
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o != '0 && !completing) |=> $stable(irq_o));

    // R8
    err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|stray_vec) |=> err_o);

    // R8
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> err_o);

endmodule

// File: tb/sim_pp_job_sched.sv
`timescale 1ns/1ps
module sim_pp_job_sched;

    localparam int NB = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NB-1:0] ld = '0, ul = '0, pdone = '0;
    logic [NB-1:0] irq, dclr, urdy, free;
    logic          err;

    int n_chk = 0, n_fail = 0, cyc = 0;
    bit wd_hit = 0;

    always #2.5 clk = ~clk;   // 200 MHz

    pp_job_sched #(.NBUF(NB)) u0 (
        .clk(clk), .rst_n(rst_n), .load_i(ld), .unload_i(ul),
        .cpu_done_i(pdone), .irq_o(irq), .done_clr_o(dclr),
        .unload_rdy_o(urdy), .free_o(free), .err_o(err)
    );

    // ---------------- reference model ----------------
    logic [1:0]    m_st [NB];   // 0 empty,1 loaded,2 active,3 done
    logic [NB-1:0] m_grant, m_prev, m_clr;
    int            m_last;
    bit            m_err;

    function automatic logic [NB-1:0] m_pick(logic [NB-1:0] req, int b);
        logic [NB-1:0] r = '0;
        for (int k = 1; k <= NB; k++) begin
            int idx = (b + k) % NB;
            if (r == '0 && req[idx]) r[idx] = 1'b1;
        end
        return r;
    endfunction

    function automatic int m_idx(logic [NB-1:0] v);
        int r = 0;
        for (int i = 0; i < NB; i++) if (v[i]) r = i;
        return r;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NB; i++) m_st[i] = 2'd0;
            m_grant = '0; m_prev = '0; m_clr = '0; m_last = NB - 1; m_err = 0;
        end else begin
            logic [NB-1:0] rise, fin, loaded, pk;
            bit cmp;
            int b;
            rise = pdone & ~m_prev;
            m_prev = pdone;
            fin = rise & m_grant;
            if ((rise & ~m_grant) != '0) m_err = 1;
            for (int i = 0; i < NB; i++) loaded[i] = (m_st[i] == 2'd1);
            cmp = (fin != '0);
            b = cmp ? m_idx(m_grant) : m_last;
            pk = (m_grant == '0 || cmp) ? m_pick(loaded, b) : '0;
            m_clr = '0;
            for (int i = 0; i < NB; i++) begin
                case (m_st[i])
                    2'd0: if (ld[i]) m_st[i] = 2'd1;
                    2'd1: if (pk[i]) m_st[i] = 2'd2;
                    2'd2: if (fin[i]) m_st[i] = 2'd3;
                    default: if (ul[i]) begin m_st[i] = 2'd0; m_clr[i] = 1'b1; end
                endcase
            end
            if (cmp) begin m_last = b; m_grant = pk; end
            else if (m_grant == '0) m_grant = pk;
        end
    end

    // processor side: done port cleared by the clear pulse
    always @(negedge clk) pdone = pdone & ~dclr;

    // ---------------- helpers ----------------
    task automatic chk(bit ok, string tag, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic step();
        @(posedge clk); @(negedge clk);
    endtask

    task automatic pulse_load(logic [NB-1:0] m);
        ld = m; step(); ld = '0;
    endtask

    task automatic pulse_unload(logic [NB-1:0] m);
        ul = m; step(); ul = '0;
    endtask

    task automatic cmp_model();
        logic [NB-1:0] e_rdy, e_free;
        for (int i = 0; i < NB; i++) begin
            e_rdy[i]  = (m_st[i] == 2'd3);
            e_free[i] = (m_st[i] == 2'd0);
        end
        chk(irq == m_grant, "R3/R5 random irq", 32'(irq), 32'(m_grant));
        chk(urdy == e_rdy && free == e_free, "R7/R9 random slots",
            {16'(urdy), 16'(free)}, {16'(e_rdy), 16'(e_free)});
        chk(dclr == m_clr && err == m_err, "R7/R8 random clr/err",
            {16'(dclr), 16'(err)}, {16'(m_clr), 16'(m_err)});
    endtask

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !wd_hit) begin
            wd_hit = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog got %0d cycles expected completion", cyc);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        int seed;
        seed = $urandom(32'd4242);
        repeat (3) @(negedge clk);
        // r1_ reset state
        chk(irq == '0 && dclr == '0 && urdy == '0 && err == 0, "R1 reset outs",
            {8'(irq), 8'(dclr), 8'(urdy), 8'(err)}, 32'h0);
        chk(free == '1, "R1 reset free", 32'(free), 32'hff);
        rst_n = 1'b1;

        // R2 latency
        pulse_load(8'h04);
        chk(irq == '0 && free[2] == 1'b0, "R2 after first edge",
            {16'(irq), 16'(free)}, 32'h0000_00fb);
        step();
        chk(irq == 8'h04, "R2 irq raised", 32'(irq), 32'h04);

        // R9 load others while running
        pulse_load(8'h21);
        chk(irq == 8'h04, "R9 irq undisturbed", 32'(irq), 32'h04);
        step();
        chk(irq == 8'h04, "R4 irq held", 32'(irq), 32'h04);

        // R4/R5 chain to 5
        pdone[2] = 1'b1; step();
        chk(irq == 8'h20, "R5 next after 2", 32'(irq), 32'h20);
        chk(urdy == 8'h04, "R4 unload ready", 32'(urdy), 32'h04);

        // R5 wrap to 0
        pdone[5] = 1'b1; step();
        chk(irq == 8'h01, "R5 wrap to 0", 32'(irq), 32'h01);

        // R8 stray done
        pdone[3] = 1'b1; step();
        chk(err == 1'b1 && irq == 8'h01, "R8 stray flag", {16'(err), 16'(irq)}, 32'h0001_0001);
        pdone[3] = 1'b0; step();
        chk(err == 1'b1, "R8 sticky", 32'(err), 32'h1);

        // R6 load on finished buffer
        pulse_load(8'h04);
        step();
        chk(urdy == 8'h24 && free[2] == 1'b0 && irq == 8'h01, "R6 load ignored",
            {8'(urdy), 8'(free), 16'(irq)}, {8'h24, 8'h00, 16'h01});

        // R7 unload on active buffer ignored
        pulse_unload(8'h01);
        chk(irq == 8'h01 && dclr == '0 && urdy == 8'h24, "R7 unload ignored",
            {8'(irq), 8'(dclr), 16'(urdy)}, {8'h01, 8'h00, 16'h24});

        // R7 drain
        pulse_unload(8'h04);
        chk(free[2] == 1'b1 && dclr == 8'h04 && urdy == 8'h20, "R7 drain",
            {8'(free), 8'(dclr), 16'(urdy)}, {8'(free | 8'h04), 8'h04, 16'h20});
        step();
        chk(dclr == '0, "R7 clear one cycle", 32'(dclr), 32'h0);

        // RELEASE to idle
        pdone[0] = 1'b1; step();
        chk(irq == '0 && urdy == 8'h21, "R4 idle after last",
            {16'(irq), 16'(urdy)}, {16'h0, 16'h21});

        // R5 search starts after last completed (0)
        pulse_unload(8'h21);
        step();
        pulse_load(8'hff);
        step();
        chk(irq == 8'h02, "R5 start after 0", 32'(irq), 32'h02);

        // constrained random
        for (int t = 0; t < 3000; t++) begin
            cmp_model();
            ld = 8'($urandom & $urandom & $urandom);
            ul = 8'($urandom & $urandom);
            if (irq != '0 && (pdone & irq) == '0 && ($urandom % 4) == 0)
                pdone = pdone | irq;
            step();
        end
        ld = '0; ul = '0;
        step();
        cmp_model();

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule